// File: doc/BRIEF.md
# TDM Time Slot Interchange Core

The core is a non-blocking switch for 8-bit channels. Eight serial receive lines and eight serial transmit lines each carry 32 channels per 125 µs frame, which gives 256 channels in each direction. A shared bit clock drives the core at twice the serial bit rate. Every receive line is converted to bytes, and each byte is stored in a 256-entry data store at address `{stream, channel}`.

Each transmit channel has its own 16-bit connection entry. The low byte of that entry is either a source address into the data store (switching mode) or a literal byte that is sent every frame (processor mode). The control byte selects the mode, the per-channel output enable and one control-channel bit. The control-channel bits leave the core on a separate serial output, one channel ahead of the traffic they belong to. A host reaches the connection entries through a simple synchronous write port and a combinational read port.

The byte for each transmit channel is fetched one channel slot early, one stream per bit time. Because of this, a switched byte appears in the current frame only when its output slot is at least two channel times after its input slot. Otherwise it appears one frame later.

Top module: `tsi_core`

## Requirements
- R1: While `rst_ni` is low and just after it rises, every `tx_oe_o` bit is 0, every `tx_o` bit is 0 and `cco_o` is 0. Reset also clears every connection entry to 0x0000.
- R2: When `frame_i` is high in a clock cycle, the next cycle is the first half of bit 7 (MSB) of channel 0. Each bit lasts two clocks. Receive bits are sampled at the end of the second clock. Transmit bits change only at the start of a bit. Bytes travel MSB first.
- R3: In switching mode, the low byte of entry `{out_stream, out_channel}` holds the source as stream in bits 7:5 and channel in bits 4:0. That output channel carries the byte received on the source stream and channel.
- R4: Any number of output channels may name the same source, and each of them carries the same byte.
- R5: Control bit 2 (entry bit 10) set selects processor mode. The low byte itself is then sent on that channel in every frame.
- R6: Control bit 0 (entry bit 8) set enables `tx_oe_o` for that stream during that channel. `oe_master_i` low forces every `tx_oe_o` bit to 0.
- R7: `proc_all_i` high makes every channel behave as if control bits 2 and 0 were both set.
- R8: A switched byte leaves in the same frame only if its output slot is at least two channel times later than its input slot. Otherwise the byte from the previous frame is sent.
- R9: During bit time k (k=0 being the first, MSB bit) of channel c, `cco_o` carries control bit 1 (entry bit 9) of stream k, channel (c+1) mod 32.
- R10: A write through `cm_we_i` takes effect at the next clock edge. `cm_rdata_o` shows the entry addressed by `cm_addr_i` (`{stream[7:5], channel[4:0]}`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, two cycles per serial bit |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | High in the last cycle of a frame |
| rx_i | input | 8 | Serial receive lines, one per stream |
| tx_o | output | 8 | Serial transmit lines, one per stream |
| tx_oe_o | output | 8 | Per-stream drive enable for the current channel |
| cco_o | output | 1 | Serial control-channel bit |
| oe_master_i | input | 1 | Master drive enable; low disables all |
| proc_all_i | input | 1 | Forces processor mode and enable on every channel |
| cm_we_i | input | 1 | Connection entry write strobe |
| cm_addr_i | input | 8 | Connection entry address `{stream, channel}` |
| cm_wdata_i | input | 16 | Entry write data, control byte in 15:8 |
| cm_rdata_o | output | 16 | Entry read data for `cm_addr_i` |

## Verification
The hardest case to reach is the boundary of the minimum-delay rule. It separates output slots that get the current frame's byte from those that get the previous frame's byte, and the stream-7 fetch lands on the same edge as the data store write. To reach it, the stimulus sends a different byte in every frame on each input channel. It then programs connections whose source channel is zero, one and two slots before the output channel, with the source stream rotating across the output streams. A model of absolute slot arithmetic predicts which frame's byte must come out of each channel.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  localparam int BYTE_W = 8;
  localparam int CM_W   = 16;
  localparam int BITS_PER_CH = 8;
  // control byte field positions (entry bits 15:8)
  localparam int CTL_EN   = 0;
  localparam int CTL_CCO  = 1;
  localparam int CTL_PROC = 2;
endpackage

// File: rtl/tsi_timing.sv
module tsi_timing #(
  parameter int CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (frame_i) cnt_o <= '0;
    else              cnt_o <= cnt_o + CNT_W'(1);
  end
endmodule

// File: rtl/tsi_rx.sv
module tsi_rx import tsi_pkg::*; #(
  parameter int N_STR = 8,
  parameter int N_CH  = 32,
  localparam int STR_W = $clog2(N_STR),
  localparam int CH_W  = $clog2(N_CH),
  localparam int AW    = STR_W + CH_W,
  localparam int N_ENT = N_STR * N_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_STR-1:0]  rx_i,
  input  logic              samp_i,
  input  logic              byte_end_i,
  input  logic [CH_W-1:0]   ch_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o
);
  logic [BYTE_W-1:0] sh_q  [N_STR];
  logic [BYTE_W-1:0] mem_q [N_ENT];

  for (genvar s = 0; s < N_STR; s++) begin : g_sp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     sh_q[s] <= '0;
      else if (samp_i) sh_q[s] <= {sh_q[s][BYTE_W-2:0], rx_i[s]};
    end
  end

  // all streams finish a byte on the same edge; each owns its address slice
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
    end else if (byte_end_i) begin
      for (int s = 0; s < N_STR; s++)
        mem_q[{STR_W'(s), ch_i}] <= {sh_q[s][BYTE_W-2:0], rx_i[s]};
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/tsi_cmem.sv
module tsi_cmem import tsi_pkg::*; #(
  parameter int AW = 8,
  localparam int N_ENT = 1 << AW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [CM_W-1:0] wdata_i,
  output logic [CM_W-1:0] hrdata_o,
  input  logic [AW-1:0]   faddr_i,
  output logic [CM_W-1:0] fdata_o
);
  logic [CM_W-1:0] mem_q [N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N_ENT; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign hrdata_o = mem_q[waddr_i];
  assign fdata_o  = mem_q[faddr_i];
endmodule

// File: rtl/tsi_tx.sv
module tsi_tx import tsi_pkg::*; #(
  parameter int N_STR = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              samp_i,
  input  logic              load_i,
  input  logic [2:0]        fetch_idx_i,
  input  logic [BYTE_W-1:0] fetch_byte_i,
  input  logic              fetch_en_i,
  output logic [N_STR-1:0]  tx_o,
  output logic [N_STR-1:0]  oe_o
);
  logic [BYTE_W-1:0] stg_q [N_STR];
  logic [BYTE_W-1:0] sh_q  [N_STR];
  logic [N_STR-1:0]  stg_en_q;

  for (genvar s = 0; s < N_STR; s++) begin : g_ps
    logic hit;
    assign hit = (fetch_idx_i == 3'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stg_q[s]    <= '0;
        stg_en_q[s] <= 1'b0;
        sh_q[s]     <= '0;
        oe_o[s]     <= 1'b0;
      end else if (samp_i) begin
        if (hit) begin
          stg_q[s]    <= fetch_byte_i;
          stg_en_q[s] <= fetch_en_i;
        end
        if (load_i) begin
          // the last stream is fetched on the load edge itself
          sh_q[s] <= hit ? fetch_byte_i : stg_q[s];
          oe_o[s] <= hit ? fetch_en_i   : stg_en_q[s];
        end else begin
          sh_q[s] <= {sh_q[s][BYTE_W-2:0], 1'b0};
        end
      end
    end

    assign tx_o[s] = sh_q[s][BYTE_W-1];
  end
endmodule

// File: rtl/tsi_core.sv
module tsi_core import tsi_pkg::*; #(
  parameter int N_STR = 8,
  parameter int N_CH  = 32,
  localparam int STR_W = $clog2(N_STR),
  localparam int CH_W  = $clog2(N_CH),
  localparam int AW    = STR_W + CH_W,
  localparam int CNT_W = CH_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [N_STR-1:0] rx_i,
  output logic [N_STR-1:0] tx_o,
  output logic [N_STR-1:0] tx_oe_o,
  output logic             cco_o,
  input  logic             oe_master_i,
  input  logic             proc_all_i,
  input  logic             cm_we_i,
  input  logic [AW-1:0]    cm_addr_i,
  input  logic [CM_W-1:0]  cm_wdata_i,
  output logic [CM_W-1:0]  cm_rdata_o
);
  logic [CNT_W-1:0]  cnt_w;
  logic [CH_W-1:0]   ch, nxt_ch;
  logic [2:0]        bitk;
  logic              samp, byte_end;
  logic [CM_W-1:0]   fe;
  logic [BYTE_W-1:0] ctl, low, dm_rd, fetch_byte;
  logic              md_proc, md_en, fetch_ok;
  logic [N_STR-1:0]  oe_q;
  logic              unused_ctl;

  tsi_timing #(.CNT_W(CNT_W)) u_tim (
    .clk_i, .rst_ni, .frame_i, .cnt_o(cnt_w)
  );

  assign ch       = cnt_w[CNT_W-1:4];
  assign bitk     = cnt_w[3:1];
  assign samp     = cnt_w[0];
  assign byte_end = samp && (bitk == 3'd7);
  assign nxt_ch   = ch + CH_W'(1);

  tsi_rx #(.N_STR(N_STR), .N_CH(N_CH)) u_rx (
    .clk_i, .rst_ni, .rx_i,
    .samp_i(samp), .byte_end_i(byte_end), .ch_i(ch),
    .rd_addr_i(low[AW-1:0]), .rd_data_o(dm_rd)
  );

  tsi_cmem #(.AW(AW)) u_cm (
    .clk_i, .rst_ni,
    .we_i(cm_we_i), .waddr_i(cm_addr_i), .wdata_i(cm_wdata_i),
    .hrdata_o(cm_rdata_o),
    .faddr_i({bitk[STR_W-1:0], nxt_ch}), .fdata_o(fe)
  );

  assign ctl        = fe[CM_W-1:BYTE_W];
  assign low        = fe[BYTE_W-1:0];
  assign md_proc    = proc_all_i | ctl[CTL_PROC];
  assign md_en      = proc_all_i | ctl[CTL_EN];
  assign fetch_byte = md_proc ? low : dm_rd;
  assign unused_ctl = ^ctl[BYTE_W-1:3];

  if (N_STR == BITS_PER_CH) begin : g_full
    assign fetch_ok = 1'b1;
  end else begin : g_part
    assign fetch_ok = (32'(bitk) < N_STR);
  end

  assign cco_o = fetch_ok & ctl[CTL_CCO];

  tsi_tx #(.N_STR(N_STR)) u_tx (
    .clk_i, .rst_ni,
    .samp_i(samp), .load_i(byte_end),
    .fetch_idx_i(bitk), .fetch_byte_i(fetch_byte), .fetch_en_i(md_en),
    .tx_o, .oe_o(oe_q)
  );

  assign tx_oe_o = oe_q & {N_STR{oe_master_i}};
endmodule

// File: rtl/tsi_core_chk.sv
module tsi_core_chk #(
  parameter int N_STR = 8,
  parameter int AW    = 8,
  parameter int CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             frame_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [N_STR-1:0] tx_o,
  input logic [N_STR-1:0] tx_oe_o,
  input logic             oe_master_i,
  input logic             proc_all_i,
  input logic             cm_we_i,
  input logic [AW-1:0]    cm_addr_i,
  input logic [15:0]      cm_wdata_i,
  input logic [15:0]      cm_rdata_o
);
  logic [5:0] pall_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pall_q <= '0;
    else if (!proc_all_i) pall_q <= '0;
    else if (pall_q < 6'd40) pall_q <= pall_q + 6'd1;
  end

  assert_frame_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (cnt_i == '0));

  assert_tx_mid_bit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i[0] |-> $stable(tx_o));

  assert_oe_per_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(oe_master_i) && (cnt_i[3:0] != 4'd0)) |-> $stable(tx_oe_o));

  assert_force_all_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pall_q >= 6'd33) && oe_master_i) |-> (tx_oe_o == {N_STR{1'b1}}));

  assert_host_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cm_we_i |=> (!$stable(cm_addr_i) || (cm_rdata_o == $past(cm_wdata_i))));
endmodule

bind tsi_core tsi_core_chk #(.N_STR(N_STR), .AW(AW), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .cnt_i(cnt_w),
  .tx_o(tx_o), .tx_oe_o(tx_oe_o), .oe_master_i(oe_master_i),
  .proc_all_i(proc_all_i), .cm_we_i(cm_we_i), .cm_addr_i(cm_addr_i),
  .cm_wdata_i(cm_wdata_i), .cm_rdata_o(cm_rdata_o)
);

// File: tb/sim_tsi_core.sv
module sim_tsi_core;
  localparam int CLK_P = 10;
  localparam int FR    = 512;

  logic        clk = 0, rst_n = 0, frame = 0, master = 0, pall = 0, we = 0;
  logic [7:0]  rx = '0, addr = '0;
  logic [15:0] wd = '0;
  logic [7:0]  tx, txoe;
  logic        cco;
  logic [15:0] rd;

  always #(CLK_P/2) clk = ~clk;

  tsi_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .rx_i(rx),
    .tx_o(tx), .tx_oe_o(txoe), .cco_o(cco),
    .oe_master_i(master), .proc_all_i(pall),
    .cm_we_i(we), .cm_addr_i(addr), .cm_wdata_i(wd), .cm_rdata_o(rd)
  );

  typedef struct {
    logic [7:0] tx;
    logic [7:0] oe;
    logic       cco;
    string      dt;
    string      ot;
  } item_t;

  item_t       q[$];
  logic [15:0] mdl[256];
  int          p, n_cmp = 0, n_bad = 0;
  logic        chk_en = 0;
  string       dtag = "R3", otag = "R6";

  function automatic logic [7:0] inb(int f, int s, int c);
    return 8'(f*37 + s*29 + c*11 + 5);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) p <= 0; else p <= p + 1;

  // stimulus: serial input and frame pulse
  always @(negedge clk) begin
    int pos, ch, k, f;
    pos = p % FR; f = p / FR; ch = pos / 16; k = (pos % 16) / 2;
    frame = (pos == FR-1);
    for (int s = 0; s < 8; s++) rx[s] = inb(f, s, ch)[7-k];
  end

  // driver side of the scoreboard
  always @(posedge clk) begin
    #1;
    if (chk_en && rst_n) begin
      item_t it;
      int pos, ch, k, f;
      pos = p % FR; f = p / FR; ch = pos / 16; k = (pos % 16) / 2;
      for (int s = 0; s < 8; s++) begin
        logic [15:0] e;
        logic [7:0]  b;
        int          num;
        e = mdl[s*32 + ch];
        if (pall || e[10]) b = e[7:0];
        else begin
          num = 32*f + ch - 2 - int'(e[4:0]);
          b = (num < 0) ? 8'h00 : inb(num / 32, int'(e[7:5]), int'(e[4:0]));
        end
        it.tx[s] = b[7-k];
        it.oe[s] = master & (pall | e[8]);
      end
      it.cco = mdl[k*32 + (ch+1) % 32][9];
      it.dt = dtag;
      it.ot = otag;
      q.push_back(it);
    end
  end

  // monitor side
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      chk(it.dt, 32'(tx), 32'(it.tx));
      chk(it.ot, 32'(txoe), 32'(it.oe));
      chk("R9", 32'(cco), 32'(it.cco));
    end
  end

  task automatic write_all();
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      we = 1; addr = 8'(a); wd = mdl[a];
    end
    @(negedge clk);
    we = 0;
  endtask

  task automatic readback();
    for (int a = 0; a < 256; a += 37) begin
      @(negedge clk);
      addr = 8'(a);
      #1;
      chk("R10", 32'(rd), 32'(mdl[a]));
    end
  endtask

  task automatic run(int nfr, bit en);
    @(posedge clk);
    chk_en = en;
    repeat (nfr*FR) @(posedge clk);
    chk_en = 0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R1 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 256; a++) mdl[a] = '0;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", 32'(txoe), 0);
    chk("R1", 32'(tx), 0);
    chk("R1", 32'(cco), 0);
    master = 1;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1", 32'(txoe), 0);
    chk("R1", 32'(tx), 0);
    addr = 8'd77;
    #1;
    chk("R1", 32'(rd), 0);

    // R3: plain switching, varied sources, some with control-channel bits
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++)
        mdl[s*32+c] = {5'd0, 1'b0, 1'(((s+c) % 3) == 0), 1'b1,
                       3'((s+3) % 8), 5'((c+5) % 32)};
    write_all();
    readback();
    run(1, 0); dtag = "R2 R3"; run(2, 1);

    // R8: source slot zero, one and two channels before the output slot
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++)
        mdl[s*32+c] = {5'd0, 1'b0, 1'(c[0]), 1'b1,
                       3'((s+1) % 8), 5'((c + 32 - (s % 3)) % 32)};
    write_all();
    run(1, 0); dtag = "R8"; run(2, 1);

    // R4 broadcast, R6 per-channel enables on even streams only
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++)
        mdl[s*32+c] = {5'd0, 1'b0, 1'(s == 3), 1'((s % 2) == 0), 3'd2, 5'd10};
    write_all();
    readback();
    run(1, 0); dtag = "R4"; otag = "R6"; run(2, 1);

    // R5: odd channels carry literal bytes, even channels switch
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++)
        if (c % 2 == 1) mdl[s*32+c] = {5'd0, 1'b1, 1'b0, 1'b1, 8'((s*16 + c) ^ 8'h5A)};
        else            mdl[s*32+c] = {5'd0, 1'b0, 1'b1, 1'b1, 3'(s), 5'((c+7) % 32)};
    write_all();
    run(1, 0); dtag = "R5"; run(2, 1);

    // R6: master enable low disables every stream
    @(negedge clk);
    master = 0;
    run(1, 0); otag = "R6"; run(1, 1);

    // R7: global processor enable over entries with mode and enable clear
    for (int a = 0; a < 256; a++) mdl[a] = {8'h00, 8'(a*3 + 1)};
    write_all();
    @(negedge clk);
    master = 1; pall = 1;
    run(1, 0); dtag = "R7"; otag = "R7"; run(2, 1);

    repeat (4) @(negedge clk);
    chk("R10", 32'(q.size()), 0);
    finish_run();
  end
endmodule